// File: doc/BRIEF.md
# Byte Manipulation Unit

This block is the byte-lane datapath of a 64-bit integer pipeline. It computes one of five operations: byte insert, byte extract, byte mask, zap and zap-not. The operations place a sized field of operand A at a byte position, pull one out, clear one, or clear a chosen set of byte lanes. The byte position comes from the low three bits of a second operand. That operand is either a full register value or a short literal with zero extension. One of four field sizes is selected, together with a low or high half. The high half handles the part of an unaligned field that spills into the next word.

The arithmetic is purely combinational. A parameter selects either a staged logarithmic shifter or plain shift operators. A second parameter adds a one-cycle output register with a valid flag. When the high-half shift distance would reach the full word width, a zero-offset flag handles that case, so a shift by 64 never reaches a shifter. Decode, register access and the general arithmetic operations are handled elsewhere in the pipeline.

Top module: `bmu_core`

## Requirements
- R1: The byte offset is bits 2:0 of the effective B, and the shift distance is that offset times 8. Effective B is `lit` zero-extended when `b_is_lit` is 1, and otherwise `op_b`. Bits of B above bit 2 do not affect insert, extract or mask. `op_b` does not affect the result while `b_is_lit` is 1.
- R2: Field encodings are as follows. `size_sel` 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. `half_hi` 0 selects the low variant and 1 the high variant. `op_sel` 0 is low insert: A zero-extended to the selected size, shifted left by the shift distance, with bits shifted past bit 63 dropped.
- R3: High insert (`op_sel` 0, `half_hi` 1) shifts the size-limited A right by 64 minus the shift distance. When the offset is 0 it gives 0.
- R4: Low extract (`op_sel` 1) shifts A right by the shift distance and then keeps only the selected size.
- R5: High extract shifts A left by 64 minus the shift distance and then keeps only the selected size. When the offset is 0, A is not shifted and only the size limit applies.
- R6: Low mask (`op_sel` 2) returns A AND NOT M. M is the selected size's all-ones field shifted left by the shift distance.
- R7: High mask returns A AND NOT M. M is the size field shifted right by 64 minus the shift distance. When the offset is 0, M is empty and A passes unchanged.
- R8: Zap (`op_sel` 3) takes B bits 7:0 as lane selects. Each set bit i clears byte lane i of A, that is, bits 8i+7:8i.
- R9: Zap-not (`op_sel` 4) keeps byte lane i of A when B bit i is set, and clears it otherwise.
- R10: `op_sel` codes 5, 6 and 7 give a result of 0.
- R11: With the output register present, `result` and `out_valid` reflect an accepted input one clock after `in_valid` is high. While `in_valid` is low, `out_valid` is 0 and `result` holds its value. Reset (`rst_n` low) clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 3 | Operation code (0 insert, 1 extract, 2 mask, 3 zap, 4 zap-not) |
| size_sel | input | 2 | Field size (0 byte, 1 word, 2 longword, 3 quadword) |
| half_hi | input | 1 | 1 selects the high variant |
| b_is_lit | input | 1 | 1 takes B from `lit` instead of `op_b` |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Register form of operand B |
| lit | input | 8 | Literal form of operand B, zero-extended |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Operation result |

## Verification
The bench sweeps all eight offsets for every operation, size and half. Offset zero on the high variants is the main target: a design that passes a 64-bit shift distance to its shifter returns A, or garbage, where the required answer is 0 for insert, the size-limited A for extract, and A unchanged for mask. Random values placed in the upper bits of B would expose a design that uses more than three offset bits. A garbage `op_b` under the literal path would expose a design that reads the wrong source. Zap and zap-not with every lane set would show an inverted lane order or a missing inversion. The illegal codes and an idle `in_valid` cycle would expose a result that leaks through or a valid flag that stays high.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

   typedef enum logic [2:0] {
      BOP_INSERT  = 3'd0,
      BOP_EXTRACT = 3'd1,
      BOP_MASK    = 3'd2,
      BOP_ZAP     = 3'd3,
      BOP_ZAPNOT  = 3'd4
   } bmu_op_e;

   typedef enum logic [1:0] {
      BSZ_BYTE = 2'd0,
      BSZ_WORD = 2'd1,
      BSZ_LONG = 2'd2,
      BSZ_QUAD = 2'd3
   } bmu_size_e;

   localparam int BMU_LANE_W = 8;

endpackage

// File: rtl/bmu_barrel.sv
// Staged logarithmic shifter, direction fixed by parameter.
module bmu_barrel #(
   parameter int DATA_W = 64,
   parameter int SH_W   = 6,
   parameter bit LEFT   = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   output logic [DATA_W-1:0] dout
);

   logic [SH_W:0][DATA_W-1:0] stg;

   assign stg[0] = din;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      if (LEFT) begin : g_left
         assign stg[s+1] = amt[s] ? (stg[s] << STEP) : stg[s];
      end else begin : g_right
         assign stg[s+1] = amt[s] ? (stg[s] >> STEP) : stg[s];
      end
   end

   assign dout = stg[SH_W];

endmodule

// File: rtl/bmu_lane_ctrl.sv
// Derives shift distances, zero-offset flag, size mask and lane selects.
module bmu_lane_ctrl
   import bmu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int LIT_W  = 8
) (
   input  logic [DATA_W-1:0]                    op_b,
   input  logic [LIT_W-1:0]                     lit,
   input  logic                                 b_is_lit,
   input  logic [1:0]                           size_sel,
   output logic [$clog2(DATA_W)-1:0]            sh_amt,
   output logic [$clog2(DATA_W)-1:0]            sh_cmp,
   output logic                                 off_zero,
   output logic [DATA_W-1:0]                    size_mask,
   output logic [DATA_W/BMU_LANE_W-1:0]         lane_sel
);

   localparam int NUM_LANES = DATA_W / BMU_LANE_W;
   localparam int OFF_W     = $clog2(NUM_LANES);
   localparam int SH_W      = $clog2(DATA_W);
   localparam int CNT_W     = OFF_W + 1;

   logic [DATA_W-1:0] b_eff;
   logic [OFF_W-1:0]  off;
   logic [CNT_W-1:0]  lanes_on;

   assign b_eff    = b_is_lit ? DATA_W'(lit) : op_b;
   assign off      = b_eff[OFF_W-1:0];
   assign sh_amt   = {off, 3'b000};
   // Complementary distance; wraps to 0 at zero offset, which is masked by off_zero.
   assign sh_cmp   = SH_W'(0) - sh_amt;
   assign off_zero = (off == '0);
   assign lane_sel = b_eff[NUM_LANES-1:0];

   always_comb begin
      unique case (bmu_size_e'(size_sel))
         BSZ_BYTE: lanes_on = CNT_W'(1);
         BSZ_WORD: lanes_on = CNT_W'(2);
         BSZ_LONG: lanes_on = CNT_W'(4);
         default:  lanes_on = CNT_W'(NUM_LANES);
      endcase
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_szlane
      assign size_mask[i*BMU_LANE_W +: BMU_LANE_W] =
         {BMU_LANE_W{(CNT_W'(i) < lanes_on)}};
   end

endmodule

// File: rtl/bmu_shift_path.sv
// Insert, extract and mask results for both halves.
module bmu_shift_path #(
   parameter int DATA_W    = 64,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic [DATA_W-1:0]         op_a,
   input  logic [DATA_W-1:0]         size_mask,
   input  logic [$clog2(DATA_W)-1:0] sh_amt,
   input  logic [$clog2(DATA_W)-1:0] sh_cmp,
   input  logic                      off_zero,
   input  logic                      half_hi,
   output logic [DATA_W-1:0]         ins_res,
   output logic [DATA_W-1:0]         ext_res,
   output logic [DATA_W-1:0]         msk_res
);

   localparam int SH_W = $clog2(DATA_W);

   logic [DATA_W-1:0] a_sz;
   logic [DATA_W-1:0] ins_lo, ins_hi, ext_lo, ext_hi, msk_lo, msk_hi;
   logic [DATA_W-1:0] msk_field;

   assign a_sz = op_a & size_mask;

   if (LOG_SHIFT) begin : g_log
      bmu_barrel #(.DATA_W(DATA_W), .SH_W(SH_W), .LEFT(1'b1)) u_ins_lo (
         .din(a_sz), .amt(sh_amt), .dout(ins_lo));
      bmu_barrel #(.DATA_W(DATA_W), .SH_W(SH_W), .LEFT(1'b0)) u_ins_hi (
         .din(a_sz), .amt(sh_cmp), .dout(ins_hi));
      bmu_barrel #(.DATA_W(DATA_W), .SH_W(SH_W), .LEFT(1'b0)) u_ext_lo (
         .din(op_a), .amt(sh_amt), .dout(ext_lo));
      bmu_barrel #(.DATA_W(DATA_W), .SH_W(SH_W), .LEFT(1'b1)) u_ext_hi (
         .din(op_a), .amt(sh_cmp), .dout(ext_hi));
      bmu_barrel #(.DATA_W(DATA_W), .SH_W(SH_W), .LEFT(1'b1)) u_msk_lo (
         .din(size_mask), .amt(sh_amt), .dout(msk_lo));
      bmu_barrel #(.DATA_W(DATA_W), .SH_W(SH_W), .LEFT(1'b0)) u_msk_hi (
         .din(size_mask), .amt(sh_cmp), .dout(msk_hi));
   end else begin : g_op
      assign ins_lo = a_sz << sh_amt;
      assign ins_hi = a_sz >> sh_cmp;
      assign ext_lo = op_a >> sh_amt;
      assign ext_hi = op_a << sh_cmp;
      assign msk_lo = size_mask << sh_amt;
      assign msk_hi = size_mask >> sh_cmp;
   end

   always_comb begin
      if (half_hi) begin
         ins_res   = off_zero ? '0 : ins_hi;
         ext_res   = (off_zero ? op_a : ext_hi) & size_mask;
         msk_field = off_zero ? '0 : msk_hi;
      end else begin
         ins_res   = ins_lo;
         ext_res   = ext_lo & size_mask;
         msk_field = msk_lo;
      end
      msk_res = op_a & ~msk_field;
   end

endmodule

// File: rtl/bmu_zap_unit.sv
// Per-lane clear under a byte-select field, optionally inverted.
module bmu_zap_unit
   import bmu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]            op_a,
   input  logic [DATA_W/BMU_LANE_W-1:0] lane_sel,
   input  logic                         keep_sel,
   output logic [DATA_W-1:0]            zap_res
);

   localparam int NUM_LANES = DATA_W / BMU_LANE_W;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      logic clr;
      assign clr = lane_sel[i] ^ keep_sel;
      assign zap_res[i*BMU_LANE_W +: BMU_LANE_W] =
         clr ? '0 : op_a[i*BMU_LANE_W +: BMU_LANE_W];
   end

endmodule

// File: rtl/bmu_core.sv
// Top: byte manipulation datapath with optional output register.
module bmu_core
   import bmu_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int LIT_W     = 8,
   parameter bit REG_OUT   = 1'b1,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op_sel,
   input  logic [1:0]        size_sel,
   input  logic              half_hi,
   input  logic              b_is_lit,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [LIT_W-1:0]  lit,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);

   localparam int NUM_LANES = DATA_W / BMU_LANE_W;
   localparam int SH_W      = $clog2(DATA_W);

   if ((DATA_W % BMU_LANE_W) != 0) begin : g_chk_lanes
      $error("bmu_core: DATA_W must be a whole number of byte lanes");
   end
   if ((NUM_LANES < 4) || ((NUM_LANES & (NUM_LANES - 1)) != 0)) begin : g_chk_pow2
      $error("bmu_core: lane count must be a power of two of at least 4");
   end
   if ((LIT_W < NUM_LANES) || (LIT_W > DATA_W)) begin : g_chk_lit
      $error("bmu_core: LIT_W must cover the lane selects and fit in DATA_W");
   end

   logic [SH_W-1:0]      sh_amt, sh_cmp;
   logic                 off_zero;
   logic [DATA_W-1:0]    size_mask;
   logic [NUM_LANES-1:0] lane_sel;
   logic [DATA_W-1:0]    ins_res, ext_res, msk_res, zap_res;
   logic [DATA_W-1:0]    comb_res;

   bmu_lane_ctrl #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_ctrl (
      .op_b      (op_b),
      .lit       (lit),
      .b_is_lit  (b_is_lit),
      .size_sel  (size_sel),
      .sh_amt    (sh_amt),
      .sh_cmp    (sh_cmp),
      .off_zero  (off_zero),
      .size_mask (size_mask),
      .lane_sel  (lane_sel)
   );

   bmu_shift_path #(.DATA_W(DATA_W), .LOG_SHIFT(LOG_SHIFT)) u_shift (
      .op_a      (op_a),
      .size_mask (size_mask),
      .sh_amt    (sh_amt),
      .sh_cmp    (sh_cmp),
      .off_zero  (off_zero),
      .half_hi   (half_hi),
      .ins_res   (ins_res),
      .ext_res   (ext_res),
      .msk_res   (msk_res)
   );

   bmu_zap_unit #(.DATA_W(DATA_W)) u_zap (
      .op_a     (op_a),
      .lane_sel (lane_sel),
      .keep_sel (op_sel == BOP_ZAPNOT),
      .zap_res  (zap_res)
   );

   always_comb begin
      case (op_sel)
         BOP_INSERT:             comb_res = ins_res;
         BOP_EXTRACT:            comb_res = ext_res;
         BOP_MASK:               comb_res = msk_res;
         BOP_ZAP, BOP_ZAPNOT:    comb_res = zap_res;
         default:                comb_res = '0;
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) result <= comb_res;
         end
      end

      AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(in_valid)); // R11
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(result)); // R11
      AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel > 3'd4) |=> (result == '0)); // R10
      AST_INS_HI_OFF0: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 3'd0 && half_hi && off_zero) |=> (result == '0)); // R3
      AST_MSK_HI_OFF0: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 3'd2 && half_hi && off_zero) |=> (result == $past(op_a))); // R7
      AST_EXT_BYTE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 3'd1 && size_sel == 2'd0) |=> (result[DATA_W-1:8] == '0)); // R4
      AST_ZAP_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 3'd3 && (&lane_sel)) |=> (result == '0)); // R8
      AST_ZAPNOT_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_sel == 3'd4 && (&lane_sel)) |=> (result == $past(op_a))); // R9
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = comb_res;
   end

endmodule

// File: tb/bmu_core_tb_top.sv
module bmu_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [2:0]  op_sel;
   logic [1:0]  size_sel;
   logic        half_hi;
   logic        b_is_lit;
   logic [63:0] op_a;
   logic [63:0] op_b;
   logic [7:0]  lit;
   logic        out_valid;
   logic [63:0] result;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   bmu_core dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .size_sel(size_sel), .half_hi(half_hi), .b_is_lit(b_is_lit),
      .op_a(op_a), .op_b(op_b), .lit(lit), .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] size_field(input logic [1:0] sz);
      case (sz)
         2'd0: return 64'h0000_0000_0000_00FF;
         2'd1: return 64'h0000_0000_0000_FFFF;
         2'd2: return 64'h0000_0000_FFFF_FFFF;
         default: return 64'hFFFF_FFFF_FFFF_FFFF;
      endcase
   endfunction

   function automatic logic [63:0] ref_calc(input logic [2:0] op, input logic [1:0] sz,
                                            input logic hi, input logic [63:0] a,
                                            input logic [63:0] b);
      int          s;
      logic [63:0] f, m, r;
      s = int'(b[2:0]) * 8;
      f = size_field(sz);
      r = '0;
      case (op)
         3'd0: begin
            if (!hi) r = (a & f) << s;
            else if (s == 0) r = '0;
            else r = (a & f) >> (64 - s);
         end
         3'd1: begin
            if (!hi) r = (a >> s) & f;
            else if (s == 0) r = a & f;
            else r = (a << (64 - s)) & f;
         end
         3'd2: begin
            if (!hi) m = f << s;
            else if (s == 0) m = '0;
            else m = f >> (64 - s);
            r = a & ~m;
         end
         3'd3, 3'd4: begin
            for (int i = 0; i < 8; i++) begin
               logic clr;
               clr = (op == 3'd3) ? b[i] : ~b[i];
               r[i*8 +: 8] = clr ? 8'h00 : a[i*8 +: 8];
            end
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input logic [2:0] op, input logic hi);
      case (op)
         3'd0: return hi ? "R3" : "R2";
         3'd1: return hi ? "R5" : "R4";
         3'd2: return hi ? "R7" : "R6";
         3'd3: return "R8";
         3'd4: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Drive at negedge, result registered at next posedge, sample at following negedge.
   task automatic run_op(input logic [2:0] op, input logic [1:0] sz, input logic hi,
                         input logic use_lit, input logic [63:0] a, input logic [63:0] b,
                         input logic [7:0] l, input string tag);
      logic [63:0] exp;
      in_valid = 1'b1; op_sel = op; size_sel = sz; half_hi = hi;
      b_is_lit = use_lit; op_a = a; op_b = b; lit = l;
      exp = ref_calc(op, sz, hi, a, use_lit ? {56'd0, l} : b);
      @(negedge clk);
      check("R11", {63'd0, out_valid}, 64'd1);
      check(tag, result, exp);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] a_fix, hold;
      void'($urandom(32'd20240607));
      rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; size_sel = '0; half_hi = 1'b0;
      b_is_lit = 1'b0; op_a = '0; op_b = '0; lit = '0;
      repeat (3) @(negedge clk);
      check("R11", {63'd0, out_valid}, 64'd0);
      check("R11", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed sweep: every op, size, half and offset; upper B bits randomised (R1).
      a_fix = 64'h0123_4567_89AB_CDEF;
      for (int op = 0; op < 8; op++)
         for (int sz = 0; sz < 4; sz++)
            for (int hi = 0; hi < 2; hi++)
               for (int off = 0; off < 8; off++) begin
                  logic [63:0] b;
                  b = {$urandom, $urandom};
                  b[2:0] = off[2:0];
                  run_op(op[2:0], sz[1:0], hi[0], 1'b0, a_fix, b, 8'h00,
                         tag_of(op[2:0], hi[0]));
               end

      // Zap corners: all lanes, no lanes, alternating (R8, R9).
      run_op(3'd3, 2'd0, 1'b0, 1'b0, a_fix, 64'hFF, 8'h0, "R8");
      run_op(3'd3, 2'd0, 1'b0, 1'b0, a_fix, 64'h00, 8'h0, "R8");
      run_op(3'd3, 2'd0, 1'b0, 1'b0, a_fix, 64'h81, 8'h0, "R8");
      run_op(3'd4, 2'd0, 1'b0, 1'b0, a_fix, 64'hFF, 8'h0, "R9");
      run_op(3'd4, 2'd0, 1'b0, 1'b0, a_fix, 64'h00, 8'h0, "R9");
      run_op(3'd4, 2'd0, 1'b0, 1'b0, a_fix, 64'h5A, 8'h0, "R9");

      // Literal path with garbage on op_b (R1).
      for (int k = 0; k < 200; k++) begin
         logic [2:0] op;
         op = 3'($urandom_range(0, 4));
         run_op(op, 2'($urandom), 1'($urandom), 1'b1, {$urandom, $urandom},
                {$urandom, $urandom}, 8'($urandom), "R1");
      end

      // Idle cycle: out_valid drops and result holds (R11).
      hold = result;
      in_valid = 1'b0; op_a = ~op_a; op_sel = 3'd3;
      @(negedge clk);
      check("R11", {63'd0, out_valid}, 64'd0);
      check("R11", result, hold);

      // Constrained random over all codes.
      for (int k = 0; k < 1500; k++) begin
         logic [2:0] op;
         logic       hi;
         op = 3'($urandom);
         hi = 1'($urandom);
         run_op(op, 2'($urandom), hi, 1'($urandom), {$urandom, $urandom},
                {$urandom, $urandom}, 8'($urandom), tag_of(op, hi));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule